// File: doc/BRIEF.md
# Chip-Sliced Write Power Admission Gate

This block decides whether a multi-level-cell write may start on a rank whose logical bank is striped over several memory chips. Each write arrives with a count of cells it will change in every chip's segment. Every chip has its own pump, and that pump can supply only a limited number of simultaneous cell changes. A single shared pump, sized like one local pump, can take over the whole segment of a chip whose local pump is full. The sum of everything drawn from all pumps must also stay within a rank-wide budget.

Requests use a valid/ready handshake. The block raises `req_ready` only when the presented write fits, so back-pressure comes from power and not from storage. A requester that sees `req_ready` low keeps `req_valid` high and `req_cnt` stable, and it waits while in-flight writes complete. On the handshake cycle the block reports a per-chip pump selection and a slot tag. From the next clock edge the write's counts are reserved against the pumps it was assigned. When the write finishes, the requester pulses `done_valid` with the tag. Each chip's count then goes back to the pump that was recorded for that chip at admission.

Top module: `pcm_pwr_admit`

## Requirements
- R1: After reset no power is reserved and every slot is free. A request whose per-chip counts are each at most LOCAL_BUDGET and whose sum is at most DIMM_BUDGET is accepted with every selection bit 0 and slot 0.
- R2: A chip's segment is served by its local pump (selection bit 0) when that chip's reserved local count plus its new count is at most LOCAL_BUDGET.
- R3: A chip that does not fit locally gets selection bit 1 (shared pump) only if its entire count fits in the shared pump's unreserved capacity (GLOBAL_BUDGET minus shared reservations). A segment is never split between pumps.
- R4: Chips that overflow are offered to the shared pump in ascending chip index, and each one reduces the capacity left for the next. If any overflowing chip cannot be covered, `req_ready` is low.
- R5: `req_ready` is low when the total reserved on all pumps plus the sum of the new counts exceeds DIMM_BUDGET.
- R6: `req_ready` needs a free slot. An accepted write takes the lowest-numbered free slot, reported on `adm_slot`.
- R7: A write is accepted on a cycle where `req_valid` and `req_ready` are both high, and `admit` marks that cycle. While `req_ready` is low nothing is reserved, however long the request is held.
- R8: A `done_valid` pulse on a busy slot returns each chip's count to the pump recorded for that chip and frees the slot, effective after the clock edge. A pulse on an idle slot changes nothing.
- R9: The decision in a cycle uses the reservations held before any release in that same cycle. A slot freed in a cycle cannot be reused in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Presented write fits now |
| req_cnt | input | NCHIP*CNT_W | Changed-cell count per chip; chip i at bits [i*CNT_W +: CNT_W] |
| admit | output | 1 | Handshake: write accepted this cycle |
| adm_src | output | NCHIP | Pump per chip: 0 local, 1 shared; valid with admit |
| adm_slot | output | SLW | Tag given to the accepted write |
| done_valid | input | 1 | A write has finished |
| done_slot | input | SLW | Tag of the finished write |

## Verification
The bench builds the block with three chips, 3-bit counts, local and shared budgets of 4, a rank budget of 12 and two slots. It presents every one of the 512 count vectors from five occupancy states: empty, partly loaded, two chips full locally, the shared pump partly used, and both slots taken. This covers single and multiple overflow, segments larger than any pump, the rank limit and slot exhaustion. Directed sequences check that a release returns counts to the pump chosen at admission, that releases of idle slots do nothing, that a release and a request in the same cycle interact correctly, and that a held request waits until capacity returns.

// File: rtl/pb_pkg.sv
package pb_pkg;
  typedef enum logic {PUMP_LOCAL = 1'b0, PUMP_GLOBAL = 1'b1} pump_sel_e;
endpackage

// File: rtl/pb_route.sv
// Combinational fit test and pump routing for one presented write.
module pb_route #(
  parameter int NCHIP         = 8,
  parameter int CNT_W         = 3,
  parameter int SUMW          = 7,
  parameter int LOCAL_BUDGET  = 4,
  parameter int GLOBAL_BUDGET = 4,
  parameter int DIMM_BUDGET   = 24
) (
  input  logic [NCHIP*CNT_W-1:0] req_cnt,
  input  logic [NCHIP*SUMW-1:0]  loc_used,
  input  logic [SUMW-1:0]        gbl_used,
  input  logic [SUMW-1:0]        tot_used,
  output logic                   fits,
  output logic [NCHIP-1:0]       src
);
  import pb_pkg::*;

  localparam logic [SUMW-1:0] LB = SUMW'(LOCAL_BUDGET);
  localparam logic [SUMW-1:0] GB = SUMW'(GLOBAL_BUDGET);
  localparam logic [SUMW-1:0] DB = SUMW'(DIMM_BUDGET);

  logic [SUMW-1:0] rem;
  logic [SUMW-1:0] cnt;
  logic [SUMW-1:0] sum;
  logic            cover_ok;

  // Overflowing chips are offered to the shared pump lowest index first.
  always_comb begin
    rem      = GB - gbl_used;
    sum      = '0;
    cnt      = '0;
    cover_ok = 1'b1;
    src      = '0;
    for (int i = 0; i < NCHIP; i++) begin
      cnt = SUMW'(req_cnt[i*CNT_W +: CNT_W]);
      sum = sum + cnt;
      if (loc_used[i*SUMW +: SUMW] + cnt > LB) begin
        if (cnt <= rem) begin
          src[i] = PUMP_GLOBAL;
          rem    = rem - cnt;
        end else begin
          cover_ok = 1'b0;
        end
      end
    end
    fits = cover_ok && (tot_used + sum <= DB);
  end
endmodule

// File: rtl/pb_slot_pick.sv
// Lowest-index free slot finder.
module pb_slot_pick #(
  parameter int NSLOT = 4,
  parameter int SLW   = 2
) (
  input  logic [NSLOT-1:0] busy,
  output logic             any_free,
  output logic [SLW-1:0]   idx
);
  always_comb begin
    any_free = 1'b0;
    idx      = '0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (!busy[s]) begin
        any_free = 1'b1;
        idx      = SLW'(s);
      end
    end
  end
endmodule

// File: rtl/pb_ledger.sv
// Reservation state: per-chip local usage, shared usage, per-slot records.
module pb_ledger #(
  parameter int NCHIP = 8,
  parameter int CNT_W = 3,
  parameter int SUMW  = 7,
  parameter int NSLOT = 4,
  parameter int SLW   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   admit,
  input  logic [NCHIP*CNT_W-1:0] adm_cnt,
  input  logic [NCHIP-1:0]       adm_src,
  input  logic [SLW-1:0]         adm_slot,
  input  logic                   done_valid,
  input  logic [SLW-1:0]         done_slot,
  output logic [NCHIP*SUMW-1:0]  loc_used,
  output logic [SUMW-1:0]        gbl_used,
  output logic [NSLOT-1:0]       slot_busy
);
  import pb_pkg::*;

  logic [NCHIP*CNT_W-1:0] tab_cnt [NSLOT];
  logic [NCHIP-1:0]       tab_src [NSLOT];
  logic [SUMW-1:0]        loc_q [NCHIP];
  logic [SUMW-1:0]        loc_d [NCHIP];
  logic [SUMW-1:0]        gbl_q, gbl_d;
  logic [NSLOT-1:0]       busy_q, busy_d;
  logic                   rel;
  logic [NCHIP*CNT_W-1:0] rel_cnt;
  logic [NCHIP-1:0]       rel_src;
  logic [SUMW-1:0]        c_in, c_out;

  assign rel     = done_valid && (int'(done_slot) < NSLOT) && busy_q[done_slot];
  assign rel_cnt = rel ? tab_cnt[done_slot] : '0;
  assign rel_src = rel ? tab_src[done_slot] : '0;

  always_comb begin
    gbl_d  = gbl_q;
    busy_d = busy_q;
    c_in   = '0;
    c_out  = '0;
    for (int i = 0; i < NCHIP; i++) begin
      loc_d[i] = loc_q[i];
      c_in     = admit ? SUMW'(adm_cnt[i*CNT_W +: CNT_W]) : '0;
      c_out    = SUMW'(rel_cnt[i*CNT_W +: CNT_W]);
      if (adm_src[i] == PUMP_GLOBAL) gbl_d = gbl_d + c_in;
      else                           loc_d[i] = loc_d[i] + c_in;
      if (rel_src[i] == PUMP_GLOBAL) gbl_d = gbl_d - c_out;
      else                           loc_d[i] = loc_d[i] - c_out;
    end
    if (admit) busy_d[adm_slot]  = 1'b1;
    if (rel)   busy_d[done_slot] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gbl_q  <= '0;
      busy_q <= '0;
      for (int i = 0; i < NCHIP; i++) loc_q[i] <= '0;
    end else begin
      gbl_q  <= gbl_d;
      busy_q <= busy_d;
      for (int i = 0; i < NCHIP; i++) loc_q[i] <= loc_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (admit) begin
      tab_cnt[adm_slot] <= adm_cnt;
      tab_src[adm_slot] <= adm_src;
    end
  end

  for (genvar g = 0; g < NCHIP; g++) begin : g_flat
    assign loc_used[g*SUMW +: SUMW] = loc_q[g];
  end
  assign gbl_used  = gbl_q;
  assign slot_busy = busy_q;
endmodule

// File: rtl/pcm_pwr_admit.sv
// Top: per-chip pump budget admission with a shared overflow pump.
module pcm_pwr_admit #(
  parameter int NCHIP         = 8,
  parameter int CNT_W         = 3,
  parameter int LOCAL_BUDGET  = 4,
  parameter int GLOBAL_BUDGET = LOCAL_BUDGET,
  parameter int DIMM_BUDGET   = 24,
  parameter int NSLOT         = 4,
  parameter int SUMW          = $clog2(DIMM_BUDGET + NCHIP * ((1 << CNT_W) - 1) + 1),
  parameter int SLW           = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [NCHIP*CNT_W-1:0] req_cnt,
  output logic                   admit,
  output logic [NCHIP-1:0]       adm_src,
  output logic [SLW-1:0]         adm_slot,
  input  logic                   done_valid,
  input  logic [SLW-1:0]         done_slot
);
  logic [NCHIP*SUMW-1:0] loc_used;
  logic [SUMW-1:0]       gbl_used;
  logic [SUMW-1:0]       tot_used;
  logic [NSLOT-1:0]      slot_busy;
  logic                  fits;
  logic                  any_free;
  logic [NCHIP-1:0]      src;
  logic [SLW-1:0]        free_idx;

  always_comb begin
    tot_used = gbl_used;
    for (int i = 0; i < NCHIP; i++) tot_used = tot_used + loc_used[i*SUMW +: SUMW];
  end

  pb_route #(
    .NCHIP(NCHIP), .CNT_W(CNT_W), .SUMW(SUMW), .LOCAL_BUDGET(LOCAL_BUDGET),
    .GLOBAL_BUDGET(GLOBAL_BUDGET), .DIMM_BUDGET(DIMM_BUDGET)
  ) u_route (
    .req_cnt(req_cnt), .loc_used(loc_used), .gbl_used(gbl_used),
    .tot_used(tot_used), .fits(fits), .src(src)
  );

  pb_slot_pick #(.NSLOT(NSLOT), .SLW(SLW)) u_pick (
    .busy(slot_busy), .any_free(any_free), .idx(free_idx)
  );

  assign req_ready = fits && any_free;
  assign admit     = req_valid && req_ready;
  assign adm_src   = src;
  assign adm_slot  = free_idx;

  pb_ledger #(
    .NCHIP(NCHIP), .CNT_W(CNT_W), .SUMW(SUMW), .NSLOT(NSLOT), .SLW(SLW)
  ) u_ledger (
    .clk(clk), .rst_n(rst_n), .admit(admit), .adm_cnt(req_cnt),
    .adm_src(adm_src), .adm_slot(adm_slot), .done_valid(done_valid),
    .done_slot(done_slot), .loc_used(loc_used), .gbl_used(gbl_used),
    .slot_busy(slot_busy)
  );
endmodule

// File: rtl/pb_chk.sv
// Property checker bound into pcm_pwr_admit.
module pb_chk #(
  parameter int NCHIP         = 8,
  parameter int CNT_W         = 3,
  parameter int LOCAL_BUDGET  = 4,
  parameter int GLOBAL_BUDGET = 4,
  parameter int DIMM_BUDGET   = 24,
  parameter int NSLOT         = 4,
  parameter int SUMW          = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   admit,
  input logic                   done_valid,
  input logic [NCHIP*CNT_W-1:0] req_cnt,
  input logic [NCHIP*SUMW-1:0]  loc_used,
  input logic [SUMW-1:0]        gbl_used,
  input logic [SUMW-1:0]        tot_used,
  input logic [NSLOT-1:0]       slot_busy
);
  logic [SUMW-1:0] req_sum;
  always_comb begin
    req_sum = '0;
    for (int i = 0; i < NCHIP; i++) req_sum = req_sum + SUMW'(req_cnt[i*CNT_W +: CNT_W]);
  end

  for (genvar g = 0; g < NCHIP; g++) begin : g_loc
    a_r2_local_cap: assert property (@(posedge clk) disable iff (!rst_n)
      loc_used[g*SUMW +: SUMW] <= SUMW'(LOCAL_BUDGET));
  end

  a_r3_global_cap: assert property (@(posedge clk) disable iff (!rst_n)
    gbl_used <= SUMW'(GLOBAL_BUDGET));

  a_r5_dimm_cap: assert property (@(posedge clk) disable iff (!rst_n)
    tot_used <= SUMW'(DIMM_BUDGET));

  a_r6_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
    admit |-> ($countones(slot_busy) < NSLOT));

  a_r7_reserve: assert property (@(posedge clk) disable iff (!rst_n)
    (admit && !done_valid) |=> (tot_used == $past(tot_used) + $past(req_sum)));

  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!admit && !done_valid) |=> ($stable(tot_used) && $stable(slot_busy)));
endmodule

bind pcm_pwr_admit pb_chk #(
  .NCHIP(NCHIP), .CNT_W(CNT_W), .LOCAL_BUDGET(LOCAL_BUDGET),
  .GLOBAL_BUDGET(GLOBAL_BUDGET), .DIMM_BUDGET(DIMM_BUDGET),
  .NSLOT(NSLOT), .SUMW(SUMW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .admit(admit), .done_valid(done_valid),
  .req_cnt(req_cnt), .loc_used(loc_used), .gbl_used(gbl_used),
  .tot_used(tot_used), .slot_busy(slot_busy)
);

// File: tb/tb_pcm_pwr_admit.sv
module tb_pcm_pwr_admit;
  localparam int CLK_P = 10;
  localparam int NC = 3, CW = 3, LB = 4, GB = 4, DB = 12, NS = 2, SLW = 1;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, done_valid = 1'b0;
  logic [NC*CW-1:0] req_cnt = '0;
  logic [SLW-1:0] done_slot = '0;
  logic req_ready, admit;
  logic [NC-1:0] adm_src;
  logic [SLW-1:0] adm_slot;

  always #(CLK_P/2) clk = ~clk;

  pcm_pwr_admit #(.NCHIP(NC), .CNT_W(CW), .LOCAL_BUDGET(LB), .GLOBAL_BUDGET(GB),
                  .DIMM_BUDGET(DB), .NSLOT(NS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cnt(req_cnt), .admit(admit), .adm_src(adm_src), .adm_slot(adm_slot),
    .done_valid(done_valid), .done_slot(done_slot));

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  int m_loc [NC];
  int m_g = 0;
  bit m_busy [NS];
  int m_cnt [NS][NC];
  bit m_src [NS][NC];
  bit e_ok;
  logic [NC-1:0] e_src;
  int e_slot;
  string e_tag;

  function automatic int cnt_of(logic [NC*CW-1:0] v, int i);
    return int'(v[i*CW +: CW]);
  endfunction

  function automatic logic [NC*CW-1:0] mk(int a, int b, int c);
    return {CW'(c), CW'(b), CW'(a)};
  endfunction

  // Expected decision from the requirements.
  function automatic void predict(logic [NC*CW-1:0] v);
    int rem = GB - m_g;
    int tot = m_g;
    int sum = 0;
    bit cov = 1'b1;
    e_src = '0;
    for (int i = 0; i < NC; i++) tot += m_loc[i];
    for (int i = 0; i < NC; i++) begin
      int c = cnt_of(v, i);
      sum += c;
      if (m_loc[i] + c > LB) begin
        if (c <= rem) begin e_src[i] = 1'b1; rem -= c; end
        else cov = 1'b0;
      end
    end
    e_slot = -1;
    for (int s = NS - 1; s >= 0; s--) if (!m_busy[s]) e_slot = s;
    e_ok = 1'b1; e_tag = "R2";
    if (!cov)         begin e_ok = 1'b0; e_tag = "R4"; end
    if (tot + sum > DB) begin e_ok = 1'b0; e_tag = "R5"; end
    if (e_slot < 0)   begin e_ok = 1'b0; e_tag = "R6"; end
  endfunction

  function automatic void commit(logic [NC*CW-1:0] v);
    m_busy[e_slot] = 1'b1;
    for (int i = 0; i < NC; i++) begin
      m_cnt[e_slot][i] = cnt_of(v, i);
      m_src[e_slot][i] = e_src[i];
      if (e_src[i]) m_g += cnt_of(v, i);
      else          m_loc[i] += cnt_of(v, i);
    end
  endfunction

  function automatic void unreserve(int s);
    if (m_busy[s]) begin
      for (int i = 0; i < NC; i++) begin
        if (m_src[s][i]) m_g -= m_cnt[s][i];
        else             m_loc[i] -= m_cnt[s][i];
      end
      m_busy[s] = 1'b0;
    end
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic probe(logic [NC*CW-1:0] v);
    @(negedge clk);
    req_cnt = v; req_valid = 1'b1;
    #1;
    predict(v);
    check(e_tag, int'(req_ready), int'(e_ok));
    if (e_ok) begin
      check("R3", int'(adm_src), int'(e_src));
      check("R6", int'(adm_slot), e_slot);
    end
    req_valid = 1'b0;
  endtask

  task automatic admit_w(logic [NC*CW-1:0] v);
    @(negedge clk);
    req_cnt = v; req_valid = 1'b1;
    #1;
    predict(v);
    check("R7", int'(admit), int'(e_ok));
    if (e_ok) check("R3", int'(adm_src), int'(e_src));
    @(posedge clk);
    if (e_ok) commit(v);
    #1 req_valid = 1'b0;
  endtask

  task automatic release_w(int s);
    @(negedge clk);
    done_valid = 1'b1; done_slot = SLW'(s);
    @(posedge clk);
    unreserve(s);
    #1 done_valid = 1'b0;
  endtask

  task automatic release_all();
    for (int s = 0; s < NS; s++) if (m_busy[s]) release_w(s);
  endtask

  task automatic sweep();
    for (int v = 0; v < (1 << (NC*CW)); v++) probe(v[NC*CW-1:0]);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    for (int i = 0; i < NC; i++) m_loc[i] = 0;
    for (int s = 0; s < NS; s++) m_busy[s] = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R1", int'(admit), 0);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty after reset, full per-chip load fits locally
    probe(mk(4, 4, 4));
    check("R1", int'(req_ready), 1);
    check("R1", int'(adm_src), 0);
    check("R1", int'(adm_slot), 0);

    sweep();                                            // empty state
    admit_w(mk(3, 1, 0)); sweep(); release_all();       // partial load
    admit_w(mk(4, 0, 4)); sweep(); release_all();       // two chips full
    admit_w(mk(4, 0, 0)); admit_w(mk(2, 3, 0));         // shared pump holds 2
    check("R3", m_g, 2);
    sweep(); release_all();
    admit_w(mk(0, 4, 0)); admit_w(mk(0, 3, 0));         // slots exhausted
    sweep(); release_all();

    // R8: release goes back to the recorded pump
    admit_w(mk(4, 0, 0)); admit_w(mk(3, 0, 0));
    release_w(0);
    probe(mk(4, 0, 0));
    check("R8", int'(req_ready), 1);
    check("R8", int'(adm_src), 0);
    probe(mk(0, 0, 2));
    check("R8", int'(req_ready), 1);
    release_all();

    // R8: release of an idle slot has no effect
    release_w(1);
    probe(mk(4, 4, 4));
    check("R8", int'(req_ready), 1);
    check("R8", int'(adm_src), 0);

    // R9: same-cycle release does not free the slot for this decision
    admit_w(mk(1, 0, 0)); admit_w(mk(0, 1, 0));
    @(negedge clk);
    done_valid = 1'b1; done_slot = 1'b0;
    req_cnt = mk(0, 0, 1); req_valid = 1'b1;
    #1;
    check("R9", int'(req_ready), 0);
    check("R9", int'(admit), 0);
    @(posedge clk);
    unreserve(0);
    #1 done_valid = 1'b0;
    @(negedge clk); #1;
    predict(mk(0, 0, 1));
    check("R9", int'(admit), 1);
    check("R6", int'(adm_slot), 0);
    @(posedge clk);
    commit(mk(0, 0, 1));
    #1 req_valid = 1'b0;
    release_all();

    // R7: held request waits without reserving, then goes through
    admit_w(mk(4, 4, 4));
    @(negedge clk);
    req_cnt = mk(0, 0, 1); req_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1 check("R7", int'(admit), 0);
      @(negedge clk);
    end
    done_valid = 1'b1; done_slot = 1'b0;
    #1 check("R7", int'(admit), 0);
    @(posedge clk);
    unreserve(0);
    #1 done_valid = 1'b0;
    @(negedge clk); #1;
    predict(mk(0, 0, 1));
    check("R7", int'(admit), 1);
    check("R7", int'(adm_src), 0);
    @(posedge clk);
    commit(mk(0, 0, 1));
    #1 req_valid = 1'b0;
    release_all();
    probe(mk(4, 4, 4));
    check("R8", int'(req_ready), 1);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule